// File: doc/BRIEF.md
# I2C Target Byte Engine with Clock Stretching

This block acts as a target on a two-wire I2C bus. It watches for START and STOP conditions and compares the first byte after START with its programmed 7-bit address. On a match it moves data bytes in either direction through one shared 8-bit data register. The bus lines are sampled through synchronizer flops on the system clock. The block only ever pulls a line low, through `scl_oe_o` and `sda_oe_o`.

Local control logic works the block through a small four-word register port. It can make the block hold SCL low at the end of every byte, either after the 8th or after the 9th clock. While SCL is held, the control logic can read what arrived, load the next byte to send, or pick the acknowledge value. Releasing the bus is done by clearing the stretch flag. A low-clock timer raises a sticky flag when SCL stays low for too long while a transfer is in progress.

Register map (offset on `reg_addr_i`):
- 0, control: bit0 enables stretching, bit1 selects the stretch point (0 = after the 9th falling edge, 1 = after the 8th), bit2 is the NACK select (0 = answer received data bytes with ACK, 1 = with NACK).
- 1: own 7-bit address in bits 6:0.
- 2: data. A write loads the byte to send. A read returns the last received byte and clears the receive-full flag.
- 3, status: bit0 busy, bit1 stretch flag, bit2 receive overrun, bit3 low-clock timeout, bit4 receive full, bit5 direction of the current transfer (1 = the controller reads). Writing a 1 to bit 1, 2 or 3 clears that flag.

Top module: `i2cs_stretch_slave`

## Requirements
- R1: After reset both line drivers are off, the status word reads 0 and the control word reads 0.
- R2: A write addressed to the own address is acknowledged on the address byte and on each data byte (while bit2 of control is 0). The received byte can then be read at offset 2. Before that read, status bit4 is 1; after it, status bit4 is 0.
- R3: With control bit2 set to 1, received data bytes are answered with NACK (SDA released on the 9th clock). The address byte is still acknowledged.
- R4: An address that does not match leaves SDA and SCL released for the rest of the transfer, and the status word stays 0.
- R5: A data byte that completes while status bit4 is still 1 sets status bit2 and is discarded, so the data register keeps the earlier byte. Writing 1 to status bit2 clears it.
- R6: With stretching enabled and control bit1 set to 0, SCL is pulled low after the 9th falling edge of each byte and status bit1 is set. SCL stays low until status bit1 is cleared.
- R7: With control bit1 set to 1, SCL is pulled low after the 8th falling edge of a received byte. During that hold, SDA follows the current value of control bit2, so a change made during the hold decides ACK or NACK.
- R8: After a matching address with the read bit (bit0) set, status bit5 is 1. Each byte written to offset 2 while SCL is held is sent MSB first. A NACK from the controller ends the transfer with both lines released.
- R9: Status bit0 is 1 while the bits of a byte are clocked. It is 0 once the 8th falling edge of that byte has passed.
- R10: Status bit3 is set once SCL has been low without a break for the configured timeout while a transfer is in progress. It stays 0 for shorter low periods and when the bus is idle. Writing 1 to status bit3 clears it.
- R11: A repeated START after an unmatched address restarts address matching, and the following matching transfer proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current offset |

## Verification
The bench drives the block with a bus controller model that releases SCL and waits for the line to go high, so held clocks show up as real waiting. It runs the following transfers:
- Plain writes, with ACK and with NACK selected, which separates address acknowledge from data acknowledge.
- A two-byte write with no read in between, which exposes overrun handling.
- A foreign address followed by a repeated START, which separates ignoring the bus from restarting matching.
- Stretching at the 9th edge, and stretching at the 8th edge with the ACK value changed during the hold.
- A read transfer ended by a NACK.
- SCL held low mid-transfer and while idle, which tells the timeout's gating from its count.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_RX,
    PH_TX,
    PH_SKIP
  } phase_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_OWN  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam int CTRL_STR_EN  = 0;
  localparam int CTRL_STR_AT8 = 1;
  localparam int CTRL_NACK    = 2;
  localparam int CTRL_W       = 3;

  localparam int STAT_BUSY = 0;
  localparam int STAT_STR  = 1;
  localparam int STAT_OVR  = 2;
  localparam int STAT_TO   = 3;
  localparam int STAT_RXF  = 4;
  localparam int STAT_RW   = 5;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2cs_low_timer.sv
module i2cs_low_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_en_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (!count_en_i)       cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      if (clr_i) flag_o <= 1'b0;
      if (count_en_i && cnt_q == LAST) flag_o <= 1'b1;
    end
  end

  p_flag_needs_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(count_en_i));
endmodule

// File: rtl/i2cs_stretch_slave.sv
module i2cs_stretch_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned TIMEOUT_MS  = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned TO_LIMIT   = CYC_PER_MS * TIMEOUT_MS;

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i), .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i), .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  phase_e            phase_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [6:0]        own_q;
  logic [7:0]        buf_q, sh_q;
  logic [3:0]        cnt_q;
  logic slot_q, busy_q, str_q, ovr_q, rx_full_q, rw_q, m_nack_q, to_flag;

  logic start_evt, stop_evt, engaged, bit_rise, bit_fall, addr_hit;
  logic wr_ctrl, wr_own, wr_data, wr_stat, rd_data, clr_str, clr_ovr, clr_to;
  logic str_at8, str_at9;

  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;
  assign engaged   = (phase_q == PH_ADDR) || (phase_q == PH_RX) || (phase_q == PH_TX);
  assign bit_rise  = engaged & scl_rise;
  assign bit_fall  = engaged & scl_fall & (cnt_q != 4'd0);
  assign addr_hit  = (sh_q[7:1] == own_q);
  assign str_at8   = ctrl_q[CTRL_STR_EN] & ctrl_q[CTRL_STR_AT8];
  assign str_at9   = ctrl_q[CTRL_STR_EN] & ~ctrl_q[CTRL_STR_AT8];

  assign wr_ctrl = reg_we_i && reg_addr_i == REG_CTRL;
  assign wr_own  = reg_we_i && reg_addr_i == REG_OWN;
  assign wr_data = reg_we_i && reg_addr_i == REG_DATA;
  assign wr_stat = reg_we_i && reg_addr_i == REG_STAT;
  assign rd_data = reg_re_i && reg_addr_i == REG_DATA;
  assign clr_str = wr_stat & reg_wdata_i[STAT_STR];
  assign clr_ovr = wr_stat & reg_wdata_i[STAT_OVR];
  assign clr_to  = wr_stat & reg_wdata_i[STAT_TO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE; ctrl_q <= '0; own_q <= '0; buf_q <= '0; sh_q <= '0;
      cnt_q <= '0; slot_q <= 1'b0; busy_q <= 1'b0; str_q <= 1'b0; ovr_q <= 1'b0;
      rx_full_q <= 1'b0; rw_q <= 1'b0; m_nack_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      if (wr_own)  own_q  <= reg_wdata_i[6:0];
      if (wr_data) buf_q  <= reg_wdata_i;
      if (rd_data) rx_full_q <= 1'b0;
      if (clr_str) str_q <= 1'b0;
      if (clr_ovr) ovr_q <= 1'b0;
      // keep the outgoing byte tracking the buffer while the clock is held
      if (str_q && phase_q == PH_TX && cnt_q == 4'd0) sh_q <= buf_q;

      if (start_evt) begin
        phase_q <= PH_ADDR; cnt_q <= '0; slot_q <= 1'b0; busy_q <= 1'b0; m_nack_q <= 1'b0;
      end else if (stop_evt) begin
        phase_q <= PH_IDLE; cnt_q <= '0; slot_q <= 1'b0; busy_q <= 1'b0;
      end else if (bit_rise) begin
        if (cnt_q == 4'd0) busy_q <= 1'b1;
        if (cnt_q < 4'd8 && phase_q != PH_TX) sh_q <= {sh_q[6:0], sda_lvl};
        if (cnt_q == 4'd8 && phase_q == PH_TX) m_nack_q <= sda_lvl;
        cnt_q <= cnt_q + 4'd1;
      end else if (bit_fall) begin
        if (cnt_q == 4'd8) begin
          busy_q <= 1'b0;
          slot_q <= 1'b1;
          unique case (phase_q)
            PH_ADDR: begin
              if (addr_hit) begin
                rw_q <= sh_q[0];
                if (str_at8) str_q <= 1'b1;
              end else phase_q <= PH_SKIP;
            end
            PH_RX: begin
              if (rx_full_q && !rd_data) ovr_q <= 1'b1;
              else begin
                buf_q     <= sh_q;
                rx_full_q <= 1'b1;
              end
              if (str_at8) str_q <= 1'b1;
            end
            default: if (str_at8) str_q <= 1'b1;
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_q  <= '0;
          slot_q <= 1'b0;
          unique case (phase_q)
            PH_ADDR: begin
              phase_q <= rw_q ? PH_TX : PH_RX;
              if (rw_q) sh_q <= buf_q;
              if (str_at9) str_q <= 1'b1;
            end
            PH_TX: begin
              if (m_nack_q) phase_q <= PH_SKIP;
              else begin
                sh_q <= buf_q;
                if (str_at9) str_q <= 1'b1;
              end
            end
            default: if (str_at9) str_q <= 1'b1;
          endcase
        end else if (phase_q == PH_TX) begin
          sh_q <= {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  i2cs_low_timer #(.LIMIT(TO_LIMIT)) u_low_timer (
    .clk_i, .rst_ni,
    .count_en_i(~scl_lvl & (phase_q != PH_IDLE)),
    .clr_i(clr_to),
    .flag_o(to_flag)
  );

  logic ack_drv, tx_drv;
  assign ack_drv  = slot_q & ((phase_q == PH_ADDR) | ((phase_q == PH_RX) & ~ctrl_q[CTRL_NACK]));
  assign tx_drv   = (phase_q == PH_TX) & ~slot_q & ~sh_q[7];
  assign sda_oe_o = ack_drv | tx_drv;
  assign scl_oe_o = str_q;

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = {{(8-CTRL_W){1'b0}}, ctrl_q};
      REG_OWN:  reg_rdata_o = {1'b0, own_q};
      REG_DATA: reg_rdata_o = buf_q;
      default:  reg_rdata_o = {2'b00, rw_q, rx_full_q, to_flag, ovr_q, str_q, busy_q};
    endcase
  end

  p_hold_ends_by_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> $past(clr_str));
  p_release_after_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_str && !bit_fall) |=> !scl_oe_o);
  p_ack_follows_ctrl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && slot_q && phase_q == PH_RX) |-> (sda_oe_o == !ctrl_q[CTRL_NACK]));
  p_overrun_discard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_fall && cnt_q == 4'd8 && phase_q == PH_RX && rx_full_q && !rd_data && !wr_data
     && !start_evt && !stop_evt) |=> (ovr_q && $stable(buf_q)));
  p_quiet_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE || phase_q == PH_SKIP) |-> !sda_oe_o);
  p_busy_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_fall && cnt_q == 4'd8 && !start_evt && !stop_evt) |=> !busy_q);
endmodule

// File: tb/i2cs_stretch_slave_tb_top.sv
`timescale 1ns/1ps
module i2cs_stretch_slave_tb_top;
  localparam int HP = 10;
  localparam logic [7:0] OWN = 8'h5A;
  localparam logic [7:0] AW  = 8'hB4;  // own address, write
  localparam logic [7:0] AR  = 8'hB5;  // own address, read

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2cs_stretch_slave #(.CLK_HZ(1_000_000), .TIMEOUT_MS(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (HP) @(negedge clk); endtask

  task automatic scl_up();
    int n = 0;
    m_scl_low = 1'b0;
    while (!scl_bus && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) check("R6 clock hold released", 0, 1);
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic peek_stat(output logic [7:0] d);
    @(negedge clk); reg_addr = 2'd3; #1 d = reg_rdata;
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; hp(); scl_up(); hp();
    m_sda_low = 1'b1; hp(); m_scl_low = 1'b1; hp();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; hp(); scl_up(); hp(); m_sda_low = 1'b0; hp();
  endtask

  task automatic m_bit_out(logic b);
    m_sda_low = !b; hp(); scl_up(); hp(); m_scl_low = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic m_write_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
    m_sda_low = 1'b0; hp(); scl_up();
    repeat (HP/2) @(negedge clk); ack = sda_bus; repeat (HP/2) @(negedge clk);
    m_scl_low = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic m_read_byte(logic nack, output logic [7:0] d);
    m_sda_low = 1'b0; d = '0;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_up();
      repeat (HP/2) @(negedge clk); d = {d[6:0], sda_bus}; repeat (HP/2) @(negedge clk);
      m_scl_low = 1'b1; repeat (3) @(negedge clk);
    end
    m_bit_out(nack);
    m_sda_low = 1'b0;
  endtask

  task automatic wait_str();
    logic [7:0] s;
    int n = 0;
    do begin peek_stat(s); n++; end while (!s[1] && n < 3000);
    if (n >= 3000) check("R6 stretch flag raised", 0, 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 scl_oe after reset", scl_oe, 0);
    check("R1 sda_oe after reset", sda_oe, 0);
    peek_stat(v); check("R1 status after reset", v, 0);
    reg_read(2'd0, v); check("R1 control after reset", v, 0);
    reg_write(2'd1, OWN);
  endtask

  task automatic t_write();
    logic ack; logic [7:0] v;
    reg_write(2'd0, 8'h00);
    m_start(); m_write_byte(AW, ack); check("R2 address ack", ack, 0);
    m_write_byte(8'hA5, ack); check("R2 data ack", ack, 0);
    m_stop();
    peek_stat(v); check("R2 rx full set", v[4], 1);
    reg_read(2'd2, v); check("R2 received byte", v, 8'hA5);
    peek_stat(v); check("R2 rx full cleared by read", v[4], 0);
  endtask

  task automatic t_nack();
    logic ack; logic [7:0] v;
    reg_write(2'd0, 8'h04);
    m_start(); m_write_byte(AW, ack); check("R3 address still acked", ack, 0);
    m_write_byte(8'h11, ack); check("R3 data nacked", ack, 1);
    m_stop(); reg_read(2'd2, v); reg_write(2'd0, 8'h00);
  endtask

  task automatic t_mismatch();
    logic ack; logic [7:0] v;
    m_start(); m_write_byte(8'h66, ack); check("R4 foreign address not acked", ack, 1);
    m_write_byte(8'h00, ack); check("R4 following byte not acked", ack, 1);
    check("R4 scl released", scl_oe, 0);
    m_stop();
    peek_stat(v); check("R4 status unchanged", v, 0);
  endtask

  task automatic t_overrun();
    logic ack; logic [7:0] v;
    m_start(); m_write_byte(AW, ack); m_write_byte(8'h12, ack); m_write_byte(8'h34, ack); m_stop();
    peek_stat(v); check("R5 overrun flag", v[2], 1);
    reg_read(2'd2, v); check("R5 first byte kept", v, 8'h12);
    reg_write(2'd3, 8'h04);
    peek_stat(v); check("R5 overrun cleared", v[2], 0);
  endtask

  task automatic t_busy();
    logic ack; logic [7:0] v; logic done = 1'b0, seen = 1'b0;
    m_start();
    fork
      begin m_write_byte(AW, ack); done = 1'b1; end
      begin while (!done) begin peek_stat(v); if (v[0]) seen = 1'b1; end end
    join
    check("R9 busy seen during byte", seen, 1);
    peek_stat(v); check("R9 busy low after byte", v[0], 0);
    m_stop();
  endtask

  task automatic serve9(logic rd_chk, logic [7:0] exp);
    logic [7:0] v;
    wait_str();
    check("R6 scl pulled", scl_oe, 1);
    repeat (50) @(negedge clk);
    check("R6 scl still held", scl_bus, 0);
    if (rd_chk) begin reg_read(2'd2, v); check("R6 byte readable during hold", v, exp); end
    reg_write(2'd3, 8'h02);
    repeat (4) @(negedge clk);
    check("R6 scl released after clear", scl_oe, 0);
  endtask

  task automatic t_stretch9();
    logic ack, ack2;
    reg_write(2'd0, 8'h01);
    m_start(); m_write_byte(AW, ack); check("R6 address ack", ack, 0);
    fork m_write_byte(8'h77, ack2); serve9(1'b0, 8'h00); join
    check("R6 data ack after hold", ack2, 0);
    fork m_stop(); serve9(1'b1, 8'h77); join
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_stretch8();
    logic ack; logic [7:0] v;
    reg_write(2'd0, 8'h03);
    m_start();
    fork m_write_byte(AW, ack); begin wait_str(); reg_write(2'd3, 8'h02); end join
    check("R7 address ack after hold", ack, 0);
    fork
      m_write_byte(8'h5C, ack);
      begin
        wait_str();
        check("R7 ack driven during hold", sda_oe, 1);
        reg_write(2'd0, 8'h07);
        repeat (4) @(negedge clk);
        check("R7 nack follows control", sda_oe, 0);
        check("R7 scl held at 8th edge", scl_oe, 1);
        reg_write(2'd3, 8'h02);
      end
    join
    check("R7 controller sees nack", ack, 1);
    m_stop(); reg_read(2'd2, v); reg_write(2'd0, 8'h00);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] v, d;
    reg_write(2'd0, 8'h01);
    m_start(); m_write_byte(AR, ack); check("R8 read address ack", ack, 0);
    peek_stat(v); check("R8 direction bit", v[5], 1);
    fork m_read_byte(1'b0, d); begin wait_str(); reg_write(2'd2, 8'h3C); reg_write(2'd3, 8'h02); end join
    check("R8 first byte sent", d, 8'h3C);
    fork m_read_byte(1'b1, d); begin wait_str(); reg_write(2'd2, 8'hC3); reg_write(2'd3, 8'h02); end join
    check("R8 second byte sent", d, 8'hC3);
    repeat (5) @(negedge clk);
    check("R8 sda released after nack", sda_oe, 0);
    check("R8 scl released after nack", scl_oe, 0);
    m_stop(); reg_write(2'd0, 8'h00);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    m_start();
    repeat (900) @(negedge clk);
    peek_stat(v); check("R10 no timeout below limit", v[3], 0);
    repeat (200) @(negedge clk);
    peek_stat(v); check("R10 timeout after limit", v[3], 1);
    reg_write(2'd3, 8'h08);
    peek_stat(v); check("R10 timeout cleared", v[3], 0);
    m_stop();
    m_scl_low = 1'b1; repeat (1500) @(negedge clk);
    peek_stat(v); check("R10 no timeout when idle", v[3], 0);
    m_scl_low = 1'b0; hp();
  endtask

  task automatic t_restart();
    logic ack; logic [7:0] v;
    m_start(); m_write_byte(8'h66, ack); check("R11 foreign address ignored", ack, 1);
    m_start(); m_write_byte(AW, ack); check("R11 address ack after repeated start", ack, 0);
    m_write_byte(8'h66, ack); check("R11 data ack", ack, 0);
    m_stop();
    reg_read(2'd2, v); check("R11 received byte", v, 8'h66);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_nack();
    t_mismatch();
    t_overrun();
    t_busy();
    t_stretch9();
    t_stretch8();
    t_read();
    t_timeout();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule